// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical page through a small set of programmable large-block windows. Two separate entry sets are kept: one searched by instruction fetches and one by loads and stores. Each entry is a pair of 32-bit words. The upper word holds the virtual block base, a block-length field and two privilege-valid bits. The lower word holds the physical block base and a two-bit protection code.

A lookup that falls inside an enabled window returns the translated page address and the read/write/execute rights granted by that window. A lookup that falls inside no window returns a miss, so that the surrounding memory-management logic can go on to segment and page translation. Entries are loaded one word at a time through a synchronous write port. The lookup result is registered and appears one clock after the request.

Top module: `blk_xlate_match`

## Requirements
- R1: A synchronous active-high reset clears every entry of both sets to all-zero words, which cannot match, and drives every output to zero.
- R2: `rsp_valid` in a cycle equals `lk_valid` of the previous cycle. Hit, address and rights for a request are presented in the cycle after that request.
- R3: Upper-word bit 1 enables an entry for supervisor lookups (`lk_user`=0) and bit 0 enables it for user lookups (`lk_user`=1). An entry whose enable bit for the current privilege is clear never hits.
- R4: Upper-word bits [31:17] hold the block base, and the length field sits in bits [12:2]. The compare mask is bits [31:17] of the upper word with every bit cleared where the length field, moved up to bits [27:17], is one. An entry hits only when the mask is non-zero and the effective address ANDed with the mask equals upper-word bits [31:17] with the low 17 bits zero. Therefore a base bit set inside the length region prevents any hit.
- R5: On a hit, `rsp_pa` equals the lower word ANDed with the mask, ORed with the effective address ANDed with the inverted mask, and then with bits [11:0] forced to zero.
- R6: The lower-word bits [1:0] form the protection code. Code 0 gives no rights, although the lookup still reports a hit. Code 2 gives read, write and execute. Codes 1 and 3 give read and execute only.
- R7: `lk_ifetch`=1 searches the instruction set and `lk_ifetch`=0 searches the data set. `wr_ifetch` selects the set written, `wr_upper`=1 writes the upper word and `wr_upper`=0 writes the lower word.
- R8: When several entries hit, the entry with the lowest index supplies the address and the rights.
- R9: On a miss, or when no request was made, `rsp_hit`, `rsp_pa`, `rsp_rd`, `rsp_wr` and `rsp_ex` are all zero.
- R10: A write takes effect for lookups made in the following cycle, and a lookup in the same cycle as the write sees the old contents. A write with `wr_idx` >= `N_ENT` changes nothing.
- R11: With `N_ENT`=0 the block never reports a hit, while `rsp_valid` still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_ifetch | input | 1 | Write target set: 1 instruction, 0 data |
| wr_upper | input | 1 | Write target word: 1 upper, 0 lower |
| wr_idx | input | IDXW (3 at default) | Entry index to write |
| wr_data | input | 32 | Word value to write |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| lk_user | input | 1 | Lookup is at user privilege |
| rsp_valid | output | 1 | Registered lookup response present |
| rsp_hit | output | 1 | A window matched |
| rsp_pa | output | 32 | Translated page address, low 12 bits zero |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |

## Verification
The entries are the only state inside the block besides the output register. A corrupted entry word therefore appears on the very next lookup that reaches that window: the hit shows up as a miss, or the translated address or rights come out wrong, in the cycle after the request. A write that lands in the wrong set or index stays hidden until an address that selects that set reaches the entry. For this reason the bench looks up through both sets at both privileges after each group of writes. Priority errors appear only when windows overlap, so overlapping windows are loaded deliberately, and a later entry is shadowed and then uncovered.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int WORD_W = 32;
  localparam int PAGE_BITS = 12;
  localparam int BASE_LSB = 17;
  localparam int LEN_LSB = 2;
  localparam int LEN_W = 11;
  localparam int SUP_EN_BIT = 1;
  localparam int USR_EN_BIT = 0;

  localparam logic [WORD_W-1:0] BASE_FIELD = {{(WORD_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
  localparam logic [WORD_W-1:0] PAGE_KEEP = {{(WORD_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  function automatic rights_t decode_rights(input logic [1:0] code);
    rights_t r;
    unique case (code)
      2'd0: r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0};
      2'd2: r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      default: r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/blkx_bank.sv
module blkx_bank #(
  parameter int N_ENT = 4,
  parameter int IDXW = 3,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_sel,
  input  logic                          wr_upper,
  input  logic [IDXW-1:0]               wr_idx,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [N_ENT-1:0][WORD_W-1:0]  up_q,
  output logic [N_ENT-1:0][WORD_W-1:0]  lo_q
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic hit_idx;
    assign hit_idx = wr_sel && (wr_idx == IDXW'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        up_q[e] <= '0;
        lo_q[e] <= '0;
      end else if (hit_idx) begin
        if (wr_upper) up_q[e] <= wr_data;
        else          lo_q[e] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/blkx_entry_cmp.sv
module blkx_entry_cmp
  import blkx_pkg::*;
(
  input  logic [WORD_W-1:0] up,
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  output logic              hit,
  output logic [WORD_W-1:0] pa,
  output logic [1:0]        code
);
  logic              en;
  logic [WORD_W-1:0] len_span;
  logic [WORD_W-1:0] mask;

  always_comb begin
    en = user ? up[USR_EN_BIT] : up[SUP_EN_BIT];
    len_span = WORD_W'(up[LEN_LSB +: LEN_W]) << BASE_LSB;
    mask = en ? (up & BASE_FIELD & ~len_span) : '0;
    hit = (mask != '0) && ((ea & mask) == (up & BASE_FIELD));
    pa = ((lo & mask) | (ea & ~mask)) & PAGE_KEEP;
    code = lo[1:0];
  end
endmodule

// File: rtl/blkx_first_hit.sv
module blkx_first_hit #(
  parameter int N_ENT = 4,
  parameter int WORD_W = 32
) (
  input  logic [N_ENT-1:0]              hit_v,
  input  logic [N_ENT-1:0][WORD_W-1:0]  pa_v,
  input  logic [N_ENT-1:0][1:0]         code_v,
  output logic                          any,
  output logic [WORD_W-1:0]             pa,
  output logic [1:0]                    code
);
  always_comb begin
    any = 1'b0;
    pa = '0;
    code = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hit_v[e]) begin
        any = 1'b1;
        pa = pa_v[e];
        code = code_v[e];
      end
    end
  end
endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import blkx_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDXW = (N_ENT < 1) ? 1 : $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_ifetch,
  input  logic              wr_upper,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              lk_valid,
  input  logic [31:0]       lk_ea,
  input  logic              lk_ifetch,
  input  logic              lk_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex
);
  logic              sel_any;
  logic [31:0]       sel_pa;
  logic [1:0]        sel_code;
  rights_t           sel_rights;

  if (N_ENT > 0) begin : g_live
    logic [1:0][N_ENT-1:0][31:0] up_q;
    logic [1:0][N_ENT-1:0][31:0] lo_q;
    logic [N_ENT-1:0][31:0]      up_s;
    logic [N_ENT-1:0][31:0]      lo_s;
    logic [N_ENT-1:0]            hit_v;
    logic [N_ENT-1:0][31:0]      pa_v;
    logic [N_ENT-1:0][1:0]       code_v;

    for (genvar b = 0; b < 2; b++) begin : g_set
      logic wr_sel;
      assign wr_sel = wr_en && (wr_ifetch == 1'(b));

      blkx_bank #(.N_ENT(N_ENT), .IDXW(IDXW), .WORD_W(32)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_sel   (wr_sel),
        .wr_upper (wr_upper),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .up_q     (up_q[b]),
        .lo_q     (lo_q[b])
      );
    end

    assign up_s = lk_ifetch ? up_q[1] : up_q[0];
    assign lo_s = lk_ifetch ? lo_q[1] : lo_q[0];

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
      blkx_entry_cmp u_cmp (
        .up   (up_s[e]),
        .lo   (lo_s[e]),
        .ea   (lk_ea),
        .user (lk_user),
        .hit  (hit_v[e]),
        .pa   (pa_v[e]),
        .code (code_v[e])
      );
    end

    blkx_first_hit #(.N_ENT(N_ENT), .WORD_W(32)) u_pick (
      .hit_v  (hit_v),
      .pa_v   (pa_v),
      .code_v (code_v),
      .any    (sel_any),
      .pa     (sel_pa),
      .code   (sel_code)
    );
  end else begin : g_empty
    logic unused_inputs;
    assign unused_inputs = ^{wr_en, wr_ifetch, wr_upper, wr_idx, wr_data,
                             lk_ea, lk_ifetch, lk_user};
    assign sel_any  = 1'b0;
    assign sel_pa   = '0;
    assign sel_code = '0;
  end

  assign sel_rights = decode_rights(sel_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid && sel_any) begin
        rsp_hit <= 1'b1;
        rsp_pa  <= sel_pa;
        rsp_rd  <= sel_rights.rd;
        rsp_wr  <= sel_rights.wr;
        rsp_ex  <= sel_rights.ex;
      end else begin
        rsp_hit <= 1'b0;
        rsp_pa  <= '0;
        rsp_rd  <= 1'b0;
        rsp_wr  <= 1'b0;
        rsp_ex  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/blkx_chk.sv
module blkx_chk #(
  parameter int N_ENT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        lk_valid,
  input logic [31:0] lk_ea,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_pa,
  input logic        rsp_rd,
  input logic        rsp_wr,
  input logic        rsp_ex
);
  // R2
  req_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  // R2
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R9
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pa == 32'h0 && !rsp_rd && !rsp_wr && !rsp_ex));
  // R9
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  // R5
  page_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_pa[11:0] == 12'h0);
  // R5
  low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rsp_hit || rsp_pa[16:12] == $past(lk_ea[16:12])));
  // R6
  write_implies_rx_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_wr |-> (rsp_rd && rsp_ex));
  // R6
  read_exec_pair_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_rd == rsp_ex);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit));

  if (N_ENT == 0) begin : g_none
    // R11
    never_hit_chk: assert property (@(posedge clk) disable iff (rst)
      !rsp_hit);
  end
endmodule

bind blk_xlate_match blkx_chk #(.N_ENT(N_ENT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_ea     (lk_ea),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_pa    (rsp_pa),
  .rsp_rd    (rsp_rd),
  .rsp_wr    (rsp_wr),
  .rsp_ex    (rsp_ex)
);

// File: tb/tb_blk_xlate_match.sv
module tb_blk_xlate_match;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_ifetch = 1'b0, wr_upper = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0, lk_ifetch = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_ea = '0;

  logic        v0, h0, r0, w0, x0;
  logic [31:0] p0;
  logic        v1, h1, r1, w1, x1;
  logic [31:0] p1;

  always #2.5 clk = ~clk;

  blk_xlate_match #(.N_ENT(N)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ifetch(wr_ifetch),
    .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_ifetch(lk_ifetch),
    .lk_user(lk_user), .rsp_valid(v0), .rsp_hit(h0), .rsp_pa(p0),
    .rsp_rd(r0), .rsp_wr(w0), .rsp_ex(x0));

  blk_xlate_match #(.N_ENT(0)) dut_empty (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ifetch(wr_ifetch),
    .wr_upper(wr_upper), .wr_idx(wr_idx[0:0]), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_ifetch(lk_ifetch),
    .lk_user(lk_user), .rsp_valid(v1), .rsp_hit(h1), .rsp_pa(p1),
    .rsp_rd(r1), .rsp_wr(w1), .rsp_ex(x1));

  logic [31:0] m_up [2][N];
  logic [31:0] m_lo [2][N];
  logic [36:0] exp_main, exp_empty;
  string       exp_tag;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          done = 0;

  function automatic logic [36:0] model(logic [31:0] ea, bit ifs, bit usr);
    logic [31:0] up, lo, span, mask, pa;
    for (int e = 0; e < N; e++) begin
      up = m_up[ifs][e];
      lo = m_lo[ifs][e];
      span = {4'b0, up[12:2], 17'b0};
      mask = (usr ? up[0] : up[1]) ? (up & 32'hFFFE_0000 & ~span) : 32'h0;
      if (mask != 0 && (ea & mask) == (up & 32'hFFFE_0000)) begin
        pa = ((lo & mask) | (ea & ~mask)) & 32'hFFFF_F000;
        case (lo[1:0])
          2'd0: return {2'b11, pa, 3'b000};
          2'd2: return {2'b11, pa, 3'b111};
          default: return {2'b11, pa, 3'b101};
        endcase
      end
    end
    return {1'b1, 36'b0};
  endfunction

  function automatic logic [31:0] upw(logic [31:0] base, logic [10:0] len, bit sup, bit usr);
    return (base & 32'hFFFE_0000) | {19'b0, len, sup, usr};
  endfunction

  task automatic check_now();
    logic [36:0] a0, a1;
    a0 = {v0, h0, p0, r0, w0, x0};
    a1 = {v1, h1, p1, r1, w1, x1};
    n_cmp += 2;
    if (a0 !== exp_main) begin
      n_bad++;
      $display("FAIL %s main act=%h exp=%h", exp_tag, a0, exp_main);
    end
    if (a1 !== exp_empty) begin
      n_bad++;
      $display("FAIL R11 (%s) empty act=%h exp=%h", exp_tag, a1, exp_empty);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_now();
    rst = 1'b1; wr_en = 0; lk_valid = 0;
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < N; e++) begin
        m_up[s][e] = '0;
        m_lo[s][e] = '0;
      end
    exp_main = '0; exp_empty = '0; exp_tag = "R1";
  endtask

  task automatic step(bit we, bit wif, bit wup, int widx, logic [31:0] wd,
                      bit lv, logic [31:0] ea, bit lif, bit lu, string tag);
    @(negedge clk);
    check_now();
    rst = 1'b0;
    wr_en = we; wr_ifetch = wif; wr_upper = wup; wr_idx = 3'(widx); wr_data = wd;
    lk_valid = lv; lk_ea = ea; lk_ifetch = lif; lk_user = lu;
    exp_main = lv ? model(ea, lif, lu) : 37'h0;
    exp_empty = {lv, 36'h0};
    exp_tag = tag;
    if (we && widx < N) begin
      if (wup) m_up[wif][widx] = wd;
      else     m_lo[wif][widx] = wd;
    end
  endtask

  task automatic wr(bit wif, bit wup, int widx, logic [31:0] wd, string tag);
    step(1, wif, wup, widx, wd, 0, 32'h0, 0, 0, tag);
  endtask

  task automatic look(logic [31:0] ea, bit lif, bit lu, string tag);
    step(0, 0, 0, 0, 32'h0, 1, ea, lif, lu, tag);
  endtask

  initial begin
    exp_main = '0; exp_empty = '0; exp_tag = "R1";
    do_reset();
    do_reset();
    // R1: nothing hits after reset
    look(32'h0000_0000, 0, 0, "R1");
    look(32'h1000_0000, 1, 1, "R1");
    // data entry 0: 128 KiB at 0x1000_0000, supervisor only, full rights
    wr(0, 1, 0, upw(32'h1000_0000, 11'h000, 1, 0), "R7");
    wr(0, 0, 0, 32'h8000_0002, "R7");
    look(32'h1001_2345, 0, 0, "R5");
    look(32'h1001_2345, 0, 1, "R3");
    look(32'h1001_2345, 1, 0, "R7");
    look(32'h1002_0000, 0, 0, "R4");
    // data entry 1: 2 MiB at 0x2000_0000, user only, code 1
    wr(0, 1, 1, upw(32'h2000_0000, 11'h00F, 0, 1), "R4");
    wr(0, 0, 1, 32'h4000_0001, "R6");
    look(32'h201A_B678, 0, 1, "R4");
    look(32'h201A_B678, 0, 0, "R3");
    look(32'h2020_0000, 0, 1, "R4");
    // instruction entry 2: both privileges, code 3
    wr(1, 1, 2, upw(32'h1000_0000, 11'h000, 1, 1), "R7");
    wr(1, 0, 2, 32'hC000_0003, "R6");
    look(32'h1000_5000, 1, 0, "R6");
    look(32'h1000_5000, 1, 1, "R7");
    // data entry 3 overlaps entry 0 with code 0
    wr(0, 1, 3, upw(32'h1000_0000, 11'h000, 1, 0), "R8");
    wr(0, 0, 3, 32'h9000_0000, "R8");
    look(32'h1001_F000, 0, 0, "R8");
    wr(0, 1, 0, 32'h0, "R8");
    look(32'h1001_F000, 0, 0, "R8");
    // base bit inside the length region blocks the hit
    wr(0, 1, 1, upw(32'h2002_0000, 11'h001, 1, 1), "R4");
    look(32'h2002_0000, 0, 0, "R4");
    look(32'h2000_0000, 0, 1, "R4");
    // zero mask: base 0 with full length never hits
    wr(0, 1, 1, upw(32'h0000_0000, 11'h7FF, 1, 1), "R4");
    look(32'h0000_1000, 0, 0, "R4");
    // out-of-range index is ignored
    wr(0, 1, 5, upw(32'h5000_0000, 11'h000, 1, 1), "R10");
    wr(0, 0, 6, 32'h7000_0002, "R10");
    look(32'h5000_0000, 0, 0, "R10");
    look(32'h1001_F000, 0, 0, "R10");
    // same-cycle write and lookup sees old contents
    step(1, 0, 1, 2, upw(32'h6000_0000, 11'h000, 1, 1), 1, 32'h6000_3000, 0, 0, "R10");
    look(32'h6000_3000, 0, 0, "R10");
    // idle cycles: no response
    step(0, 0, 0, 0, 32'h0, 0, 32'h6000_3000, 0, 0, "R2");
    look(32'h6000_3000, 0, 1, "R2");
    step(0, 0, 0, 0, 32'h0, 0, 32'h0, 0, 0, "R9");
    // reset clears entries
    do_reset();
    look(32'h6000_3000, 0, 0, "R1");
    look(32'h1000_5000, 1, 0, "R1");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] bases [4] = '{32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 32'h8000_0000};
      logic [10:0] lens [5] = '{11'h000, 11'h001, 11'h003, 11'h00F, 11'h07F};
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        if ($urandom_range(0, 1) == 1)
          wr($urandom_range(0, 1), 1, $urandom_range(0, 5),
             upw(bases[$urandom_range(0, 3)], lens[$urandom_range(0, 4)],
                 $urandom_range(0, 1), $urandom_range(0, 1)), "R8");
        else
          wr($urandom_range(0, 1), 0, $urandom_range(0, 5), $urandom(), "R8");
      end else if (r < 9) begin
        look(bases[$urandom_range(0, 3)] | ($urandom() & 32'h0FFF_FFFF),
             $urandom_range(0, 1), $urandom_range(0, 1), "R8");
      end else begin
        step(0, 0, 0, 0, 32'h0, 0, $urandom(), 0, 0, "R2");
      end
    end
    @(negedge clk);
    check_now();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule